// File: doc/BRIEF.md
# Paged TLB Lookup with Access Rights

This block is a small fully associative translation lookaside buffer for a 32-bit processor memory unit. Each entry covers a pair of adjacent virtual pages, an even page and an odd page. Each half of the pair carries its own valid flag, writable (dirty) flag, read-inhibit flag, execute-inhibit flag, cache attribute and frame number. A lookup takes a virtual address, an address-space identifier and an access kind. One cycle later it returns either a translated physical address with the cache attribute of the page, or a coded fault that names the first rule the access broke.

Software fills and inspects entries through an indexed write port and an indexed read port. Both ports carry each half in the 32-bit page-descriptor ("EntryLo") word layout. The page size of each entry comes from a mask field, so one buffer can hold 4 KiB, 16 KiB, 64 KiB and larger pages side by side.

Top module: `tlb_lookup`

## Requirements
- R1: While reset is asserted and after it is released, `rsp_valid` is 0 and every entry reads back as all zeros on the read port, with all flags, the mask and the identifier cleared.
- R2: `rsp_valid` is 1 exactly in the cycle after a cycle where `req_valid` was 1. The response fields belong to that request.
- R3: An entry matches when the address bits above its page-pair mask equal the stored page-pair number (`wr_vpn2` holds address bits 31:13). It must also be global or hold an identifier equal to `req_asid`. The global flag is set only when bit 0 of both descriptor words written to the entry is 1.
- R4: When no entry matches, the result code is 4'hE (-2).
- R5: The half is chosen by the address bit just above the page offset: bit 12+k, where the mask field `wr_pmask` holds ones in its low k bits. When that bit is 0 the even half is used, and when it is 1 the odd half is used.
- R6: If the chosen half is not valid, the code is 4'hD (-3) for every access kind. This takes priority over every other fault.
- R7: An instruction fetch (`req_acc`=2'b00) to a valid half with execute-inhibit set gives 4'hA (-6).
- R8: A data load (`req_acc`=2'b01, and 2'b11 behaves the same) to a valid half with read-inhibit set gives 4'hB (-5). Read-inhibit has no effect on fetches.
- R9: A store (`req_acc`=2'b10) to a valid half with the dirty flag clear gives 4'hC (-4). Neither inhibit flag affects stores.
- R10: On a hit the code is 4'h0. The physical address is the frame number placed at bits 31:12, ORed with the address bits below the selecting bit. `rsp_cattr` is the half's cache attribute. On any fault both fields are 0.
- R11: When several entries match, the lowest-numbered entry gives the result.
- R12: A write stores from each descriptor word: valid from bit 1, dirty from bit 2, the cache attribute from bits 5:3, the frame number from bits 25:6, execute-inhibit from bit 30 and read-inhibit from bit 31. Bits 29:26 are dropped.
- R13: The read port rebuilds each descriptor word with the global flag in bit 0 and every stored field at the position given in R12. Bits 29:26 read as 0. It also returns the page-pair number, identifier and mask of the indexed entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_va | input | 32 | Virtual address to translate |
| req_asid | input | ASID_W | Current address-space identifier |
| req_acc | input | 2 | Access kind: 00 fetch, 01 load, 10 store |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_code | output | 4 | 0 hit; E no match; D invalid; C dirty; B read-inhibit; A execute-inhibit |
| rsp_pa | output | 32 | Physical address on a hit, else 0 |
| rsp_cattr | output | 3 | Cache attribute on a hit, else 0 |
| wr_en | input | 1 | Entry write strobe |
| wr_idx | input | IDX_W | Entry written |
| wr_vpn2 | input | 19 | Page-pair number (address bits 31:13) |
| wr_asid | input | ASID_W | Identifier stored with the entry |
| wr_pmask | input | 12 | Page mask, ones from bit 0 upward |
| wr_lo0 | input | 32 | Even-half descriptor word |
| wr_lo1 | input | 32 | Odd-half descriptor word |
| rd_idx | input | IDX_W | Entry read |
| rd_vpn2 | output | 19 | Stored page-pair number |
| rd_asid | output | ASID_W | Stored identifier |
| rd_pmask | output | 12 | Stored page mask |
| rd_lo0 | output | 32 | Rebuilt even-half descriptor word |
| rd_lo1 | output | 32 | Rebuilt odd-half descriptor word |

## Verification
Directed lookups use entries with 4 KiB and 16 KiB pages and hit both halves. They run the same address under all three access kinds, so each fault rule is shown to apply only to its own access kind. Pages with several flags set show the fault order: an invalid half that also has both inhibit flags set, and a writable page with both inhibit flags set. Overlapping entries that differ only in identifier or index separate the identifier/global rule from the lowest-index priority. Random writes and lookups over a few address windows are then compared every cycle against a behavioural model, and a final read-back of every entry checks the packing of the descriptor words.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int VA_W     = 32;
  localparam int PA_W     = 32;
  localparam int LO_W     = 32;
  localparam int OFF_W    = 12;
  localparam int PAIR_LSB = OFF_W + 1;
  localparam int VPN2_W   = VA_W - PAIR_LSB;
  localparam int PMASK_W  = 12;
  localparam int PFN_W    = PA_W - OFF_W;
  localparam int PFN_LSB  = 6;
  localparam int XI_BIT   = 30;
  localparam int RI_BIT   = 31;
  localparam int CODE_W   = 4;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_LOAD2 = 2'b11
  } acc_e;

  localparam logic [CODE_W-1:0] RC_HIT     = 4'h0;
  localparam logic [CODE_W-1:0] RC_NOMATCH = 4'hE;
  localparam logic [CODE_W-1:0] RC_INVALID = 4'hD;
  localparam logic [CODE_W-1:0] RC_DIRTY   = 4'hC;
  localparam logic [CODE_W-1:0] RC_RDINH   = 4'hB;
  localparam logic [CODE_W-1:0] RC_XINH    = 4'hA;

  typedef struct packed {
    logic             v;
    logic             d;
    logic             ri;
    logic             xi;
    logic [2:0]       ca;
    logic [PFN_W-1:0] pfn;
  } half_t;

  typedef struct packed {
    logic [VPN2_W-1:0]  vpn2;
    logic [PMASK_W-1:0] pmask;
    logic               g;
    half_t              h0;
    half_t              h1;
  } entry_t;

  // Mask covering the page offset plus the even/odd select bit.
  function automatic logic [VA_W-1:0] full_mask(input logic [PMASK_W-1:0] pm);
    return {{(VA_W-PMASK_W-PAIR_LSB){1'b0}}, pm, {PAIR_LSB{1'b1}}};
  endfunction

  function automatic logic vpn_equal(input logic [VA_W-1:0] va,
                                     input logic [VPN2_W-1:0] vpn2,
                                     input logic [VA_W-1:0] m);
    return ((va ^ {vpn2, {PAIR_LSB{1'b0}}}) & ~m) == '0;
  endfunction

  function automatic logic odd_half(input logic [VA_W-1:0] va,
                                    input logic [VA_W-1:0] m);
    return |(va & m & ~(m >> 1));
  endfunction

  function automatic logic [PA_W-1:0] phys_addr(input logic [PFN_W-1:0] pfn,
                                                input logic [VA_W-1:0] va,
                                                input logic [VA_W-1:0] m);
    return {pfn, {OFF_W{1'b0}}} | (va & (m >> 1));
  endfunction

  function automatic half_t unpack_lo(input logic [LO_W-1:0] lo);
    half_t h;
    h.v   = lo[1];
    h.d   = lo[2];
    h.ca  = lo[5:3];
    h.pfn = lo[PFN_LSB +: PFN_W];
    h.xi  = lo[XI_BIT];
    h.ri  = lo[RI_BIT];
    return h;
  endfunction

  function automatic logic [LO_W-1:0] pack_lo(input half_t h, input logic g);
    logic [LO_W-1:0] w;
    w = '0;
    w[0] = g;
    w[1] = h.v;
    w[2] = h.d;
    w[5:3] = h.ca;
    w[PFN_LSB +: PFN_W] = h.pfn;
    w[XI_BIT] = h.xi;
    w[RI_BIT] = h.ri;
    return w;
  endfunction

  // Fixed fault order: invalid, execute-inhibit, read-inhibit, dirty.
  function automatic logic [CODE_W-1:0] rights_code(input half_t h, input acc_e acc);
    logic is_load;
    is_load = (acc == ACC_LOAD) || (acc == ACC_LOAD2);
    if (!h.v)                           return RC_INVALID;
    else if (acc == ACC_FETCH && h.xi)  return RC_XINH;
    else if (is_load && h.ri)           return RC_RDINH;
    else if (acc == ACC_STORE && !h.d)  return RC_DIRTY;
    else                                return RC_HIT;
  endfunction

endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VPN2_W-1:0]   wr_vpn2,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic [PMASK_W-1:0]  wr_pmask,
  input  logic [LO_W-1:0]     wr_lo0,
  input  logic [LO_W-1:0]     wr_lo1,
  output entry_t              ent_q  [ENTRIES],
  output logic [ASID_W-1:0]   asid_q [ENTRIES]
);

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
    entry_t            ent_r;
    logic [ASID_W-1:0] asid_r;
    logic              wr_hit;

    assign wr_hit = wr_en && (wr_idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_r  <= '0;
        asid_r <= '0;
      end else if (wr_hit) begin
        ent_r.vpn2  <= wr_vpn2;
        ent_r.pmask <= wr_pmask;
        ent_r.g     <= wr_lo0[0] & wr_lo1[0];
        ent_r.h0    <= unpack_lo(wr_lo0);
        ent_r.h1    <= unpack_lo(wr_lo1);
        asid_r      <= wr_asid;
      end
    end

    assign ent_q[gi]  = ent_r;
    assign asid_q[gi] = asid_r;
  end

endmodule

// File: rtl/tlb_match_vec.sv
module tlb_match_vec
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8
) (
  input  entry_t              ents  [ENTRIES],
  input  logic [ASID_W-1:0]   asids [ENTRIES],
  input  logic [VA_W-1:0]     va,
  input  logic [ASID_W-1:0]   asid,
  output logic [ENTRIES-1:0]  hit_vec
);

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    logic [VA_W-1:0] m;
    logic            page_eq;
    logic            space_ok;

    assign m        = full_mask(ents[gi].pmask);
    assign page_eq  = vpn_equal(va, ents[gi].vpn2, m);
    assign space_ok = ents[gi].g || (asids[gi] == asid);
    assign hit_vec[gi] = page_eq && space_ok;
  end

endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] hit_vec,
  output logic               hit_any,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [ENTRIES-1:0] sel_onehot
);

  always_comb begin
    hit_any    = 1'b0;
    hit_idx    = '0;
    sel_onehot = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i] && !hit_any) begin
        hit_any       = 1'b1;
        hit_idx       = IDX_W'(i);
        sel_onehot[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tlb_rights.sv
module tlb_rights
  import tlb_pkg::*;
(
  input  entry_t             ent,
  input  logic [VA_W-1:0]    va,
  input  logic [1:0]         acc,
  output logic               odd_sel,
  output logic [CODE_W-1:0]  code,
  output logic [PA_W-1:0]    pa,
  output logic [2:0]         cattr
);

  logic [VA_W-1:0] m;
  half_t           h;

  assign m       = full_mask(ent.pmask);
  assign odd_sel = odd_half(va, m);
  assign h       = odd_sel ? ent.h1 : ent.h0;

  always_comb begin
    code  = rights_code(h, acc_e'(acc));
    pa    = '0;
    cattr = '0;
    if (code == RC_HIT) begin
      pa    = phys_addr(h.pfn, va, m);
      cattr = h.ca;
    end
  end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [31:0]         req_va,
  input  logic [ASID_W-1:0]   req_asid,
  input  logic [1:0]          req_acc,
  output logic                rsp_valid,
  output logic [3:0]          rsp_code,
  output logic [31:0]         rsp_pa,
  output logic [2:0]          rsp_cattr,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [18:0]         wr_vpn2,
  input  logic [ASID_W-1:0]   wr_asid,
  input  logic [11:0]         wr_pmask,
  input  logic [31:0]         wr_lo0,
  input  logic [31:0]         wr_lo1,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [18:0]         rd_vpn2,
  output logic [ASID_W-1:0]   rd_asid,
  output logic [11:0]         rd_pmask,
  output logic [31:0]         rd_lo0,
  output logic [31:0]         rd_lo1
);

  entry_t              ents  [ENTRIES];
  logic [ASID_W-1:0]   asids [ENTRIES];

  // Internal events brought out for the checker.
  logic [ENTRIES-1:0]  hit_vec;
  logic [ENTRIES-1:0]  sel_onehot;
  logic                hit_any;
  logic [IDX_W-1:0]    hit_idx;
  logic                odd_sel;
  logic [CODE_W-1:0]   rights_c;
  logic [PA_W-1:0]     rights_pa;
  logic [2:0]          rights_ca;
  logic [CODE_W-1:0]   code_d;
  entry_t              sel_ent;

  tlb_entry_array #(.ENTRIES(ENTRIES), .ASID_W(ASID_W), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_vpn2  (wr_vpn2),
    .wr_asid  (wr_asid),
    .wr_pmask (wr_pmask),
    .wr_lo0   (wr_lo0),
    .wr_lo1   (wr_lo1),
    .ent_q    (ents),
    .asid_q   (asids)
  );

  tlb_match_vec #(.ENTRIES(ENTRIES), .ASID_W(ASID_W)) u_match (
    .ents    (ents),
    .asids   (asids),
    .va      (req_va),
    .asid    (req_asid),
    .hit_vec (hit_vec)
  );

  tlb_prio_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .hit_vec    (hit_vec),
    .hit_any    (hit_any),
    .hit_idx    (hit_idx),
    .sel_onehot (sel_onehot)
  );

  assign sel_ent = ents[hit_idx];

  tlb_rights u_rights (
    .ent     (sel_ent),
    .va      (req_va),
    .acc     (req_acc),
    .odd_sel (odd_sel),
    .code    (rights_c),
    .pa      (rights_pa),
    .cattr   (rights_ca)
  );

  assign code_d = hit_any ? rights_c : RC_NOMATCH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RC_HIT;
      rsp_pa    <= '0;
      rsp_cattr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_code  <= code_d;
        rsp_pa    <= hit_any ? rights_pa : '0;
        rsp_cattr <= hit_any ? rights_ca : '0;
      end
    end
  end

  assign rd_vpn2  = ents[rd_idx].vpn2;
  assign rd_asid  = asids[rd_idx];
  assign rd_pmask = ents[rd_idx].pmask;
  assign rd_lo0   = pack_lo(ents[rd_idx].h0, ents[rd_idx].g);
  assign rd_lo1   = pack_lo(ents[rd_idx].h1, ents[rd_idx].g);

endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [31:0]        req_va,
  input logic               rsp_valid,
  input logic [3:0]         rsp_code,
  input logic [31:0]        rsp_pa,
  input logic [2:0]         rsp_cattr,
  input logic               wr_en,
  input logic [IDX_W-1:0]   wr_idx,
  input logic [31:0]        wr_lo0,
  input logic [IDX_W-1:0]   rd_idx,
  input logic [31:0]        rd_lo0,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] sel_onehot,
  input logic               hit_any
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R11
  single_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_onehot) && (($countones(sel_onehot) == 1) == (hit_vec != '0)));

  // R4
  nomatch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit_any) |=> (rsp_code == 4'hE && rsp_pa == '0));

  // R10
  hit_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 4'h0) |-> rsp_pa[11:0] == $past(req_va[11:0]));

  // R10
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 4'h0) |-> (rsp_pa == '0 && rsp_cattr == '0));

  // R12
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_idx != $past(wr_idx)) ||
              (rd_lo0[31:30] == $past(wr_lo0[31:30]) &&
               rd_lo0[29:26] == 4'h0 &&
               rd_lo0[25:1]  == $past(wr_lo0[25:1])));

endmodule

bind tlb_lookup tlb_lookup_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_va     (req_va),
  .rsp_valid  (rsp_valid),
  .rsp_code   (rsp_code),
  .rsp_pa     (rsp_pa),
  .rsp_cattr  (rsp_cattr),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_lo0     (wr_lo0),
  .rd_idx     (rd_idx),
  .rd_lo0     (rd_lo0),
  .hit_vec    (hit_vec),
  .sel_onehot (sel_onehot),
  .hit_any    (hit_any)
);

// File: tb/tlb_lookup_tb_top.sv
module tlb_lookup_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [3:0]  rsp_code;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_cattr;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [18:0] wr_vpn2 = '0;
  logic [7:0]  wr_asid = '0;
  logic [11:0] wr_pmask = '0;
  logic [31:0] wr_lo0 = '0;
  logic [31:0] wr_lo1 = '0;
  logic [3:0]  rd_idx = '0;
  logic [18:0] rd_vpn2;
  logic [7:0]  rd_asid;
  logic [11:0] rd_pmask;
  logic [31:0] rd_lo0;
  logic [31:0] rd_lo1;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  tlb_lookup #(.ENTRIES(16), .ASID_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_va(req_va), .req_asid(req_asid), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_pa(rsp_pa), .rsp_cattr(rsp_cattr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_asid(wr_asid),
    .wr_pmask(wr_pmask), .wr_lo0(wr_lo0), .wr_lo1(wr_lo1),
    .rd_idx(rd_idx), .rd_vpn2(rd_vpn2), .rd_asid(rd_asid), .rd_pmask(rd_pmask),
    .rd_lo0(rd_lo0), .rd_lo1(rd_lo1)
  );

  // Behavioural reference: plain arrays holding the raw words written.
  logic [18:0] m_vpn2 [16];
  logic [7:0]  m_asid [16];
  logic [11:0] m_pm   [16];
  logic [31:0] m_lo0  [16];
  logic [31:0] m_lo1  [16];
  string       tag_q[$];

  logic        exp_v = 1'b0;
  logic [3:0]  exp_code = '0;
  logic [31:0] exp_pa = '0;
  logic [2:0]  exp_ca = '0;
  string       exp_tag = "";

  task automatic model_lookup(input logic [31:0] va, input logic [7:0] asid,
                              input logic [1:0] acc);
    logic [31:0] lo;
    logic [31:0] mk;
    logic        glob;
    exp_code = 4'hE; exp_pa = 0; exp_ca = 0;
    for (int i = 0; i < 16; i++) begin
      mk   = (32'(m_pm[i]) << 13) + 32'h1FFF;
      glob = m_lo0[i][0] && m_lo1[i][0];
      if (((va | mk) == ((32'(m_vpn2[i]) << 13) | mk)) && (glob || m_asid[i] == asid)) begin
        lo = ((va & (mk - (mk >> 1))) != 0) ? m_lo1[i] : m_lo0[i];
        if (lo[1] == 1'b0)                     exp_code = 4'hD;
        else if (acc == 2'b00 && lo[30])       exp_code = 4'hA;
        else if (acc[0] == 1'b1 && lo[31])     exp_code = 4'hB;
        else if (acc == 2'b10 && lo[2] == 1'b0) exp_code = 4'hC;
        else begin
          exp_code = 4'h0;
          exp_pa   = ((lo >> 6) << 12) | (va & (mk >> 1));
          exp_ca   = lo[5:3];
        end
        break;
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_v = 1'b0;
      for (int i = 0; i < 16; i++) begin
        m_vpn2[i] = 0; m_asid[i] = 0; m_pm[i] = 0; m_lo0[i] = 0; m_lo1[i] = 0;
      end
    end else begin
      exp_v = req_valid;
      if (req_valid) begin
        model_lookup(req_va, req_asid, req_acc);
        exp_tag = (tag_q.size() > 0) ? tag_q.pop_front() : "";
      end
      if (wr_en) begin
        m_vpn2[wr_idx] = wr_vpn2; m_asid[wr_idx] = wr_asid; m_pm[wr_idx] = wr_pmask;
        m_lo0[wr_idx]  = wr_lo0;  m_lo1[wr_idx]  = wr_lo1;
      end
    end
  end

  function automatic string code_tag(input logic [3:0] c);
    case (c)
      4'h0: return "R10";
      4'hE: return "R4";
      4'hD: return "R6";
      4'hC: return "R9";
      4'hB: return "R8";
      default: return "R7";
    endcase
  endfunction

  // Compared away from the active edge, on every clock.
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rsp_valid !== exp_v) begin
        fails++;
        $display("FAIL R2 rsp_valid actual=%0b expected=%0b", rsp_valid, exp_v);
      end
      if (exp_v) begin
        checks++;
        if (rsp_code !== exp_code || rsp_pa !== exp_pa || rsp_cattr !== exp_ca) begin
          fails++;
          $display("FAIL %s code/pa/ca actual=%h/%h/%h expected=%h/%h/%h",
                   (exp_tag != "") ? exp_tag : code_tag(exp_code),
                   rsp_code, rsp_pa, rsp_cattr, exp_code, exp_pa, exp_ca);
        end
      end
    end
  end

  function automatic logic [31:0] mk_lo(input bit g, input bit v, input bit d,
                                        input logic [2:0] ca, input logic [19:0] pfn,
                                        input bit xi, input bit ri);
    return (32'(ri) << 31) | (32'(xi) << 30) | (32'(pfn) << 6) |
           (32'(ca) << 3) | (32'(d) << 2) | (32'(v) << 1) | 32'(g);
  endfunction

  task automatic look(input logic [31:0] va, input logic [7:0] asid,
                      input logic [1:0] acc, input string tag);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_va = va; req_asid = asid; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] vbase, input logic [7:0] asid,
                    input logic [11:0] pm, input logic [31:0] lo0, input logic [31:0] lo1);
    wr_en = 1'b1; wr_idx = idx; wr_vpn2 = vbase[31:13]; wr_asid = asid;
    wr_pmask = pm; wr_lo0 = lo0; wr_lo1 = lo1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s read port actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  logic [31:0] bases [4];

  initial begin
    bases[0] = 32'h1000_0000; bases[1] = 32'h2000_0000;
    bases[2] = 32'h3000_0000; bases[3] = 32'h4000_0000;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    chk_rd({31'b0, rsp_valid}, 32'h0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_rd({31'b0, rsp_valid}, 32'h0, "R1");
    rd_idx = 4'd5; #1;
    chk_rd(rd_lo0 | rd_lo1 | 32'(rd_vpn2) | 32'(rd_asid) | 32'(rd_pmask), 32'h0, "R1");
    @(negedge clk);
    look(32'h0040_0000, 8'd0, 2'b01, "R1/R4");

    wr(4'd0, 32'h1000_0000, 8'd5, 12'h000,
       mk_lo(0,1,1,3'd3,20'h12345,0,0), mk_lo(0,1,0,3'd2,20'h22222,1,0));
    wr(4'd1, 32'h2000_0000, 8'd9, 12'h003,
       mk_lo(1,1,1,3'd4,20'h40000,0,1), mk_lo(1,0,1,3'd0,20'h41000,0,0));
    wr(4'd2, 32'h1000_0000, 8'd5, 12'h000,
       mk_lo(0,1,1,3'd1,20'h0AAAA,0,0), mk_lo(0,1,1,3'd1,20'h0AAAB,0,0));
    wr(4'd3, 32'h1000_0000, 8'd6, 12'h000,
       mk_lo(0,1,1,3'd5,20'h0BBBB,0,0), mk_lo(0,0,0,3'd0,20'h0,0,0));
    wr(4'd4, 32'h3000_0000, 8'd7, 12'h000,
       mk_lo(1,1,1,3'd0,20'h50000,0,0), mk_lo(0,1,1,3'd0,20'h50001,0,0));
    wr(4'd5, 32'h4000_0000, 8'd1, 12'h000,
       mk_lo(0,0,1,3'd0,20'h60000,1,1), mk_lo(0,1,1,3'd6,20'h60001,1,1) | 32'h3C00_0000);

    look(32'h1000_0123, 8'd5, 2'b00, "R11/R10");
    look(32'h1000_1456, 8'd5, 2'b00, "R7/R5");
    look(32'h1000_1456, 8'd5, 2'b01, "R5");
    look(32'h1000_1456, 8'd5, 2'b10, "R9");
    look(32'h1000_0010, 8'd6, 2'b01, "R3");
    look(32'h1000_0010, 8'd7, 2'b01, "R3/R4");
    look(32'h2000_2ABC, 8'd1, 2'b01, "R8");
    look(32'h2000_2ABC, 8'd1, 2'b00, "R8/R10");
    look(32'h2000_2ABC, 8'd1, 2'b10, "R9");
    look(32'h2000_6ABC, 8'd1, 2'b01, "R5/R6");
    look(32'h3000_0000, 8'd1, 2'b01, "R3");
    look(32'h3000_0004, 8'd7, 2'b01, "R3");
    look(32'h4000_0000, 8'd1, 2'b00, "R6");
    look(32'h4000_1000, 8'd1, 2'b10, "R9");
    look(32'h4000_1000, 8'd1, 2'b01, "R8");
    look(32'h4000_1000, 8'd1, 2'b00, "R7");
    @(negedge clk);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] b;
      b = bases[$urandom % 4];
      if ($urandom % 6 == 0) begin
        logic [11:0] pm;
        case ($urandom % 3)
          0: pm = 12'h000;
          1: pm = 12'h003;
          default: pm = 12'h00F;
        endcase
        wr(4'(8 + ($urandom % 8)), b | ($urandom & 32'h0001_E000), 8'($urandom % 4),
           pm, $urandom, $urandom);
      end else begin
        look(b | ($urandom & 32'h0001_FFFF), 8'($urandom % 4), 2'($urandom % 3), "");
      end
    end
    @(negedge clk);
    @(negedge clk);

    for (int i = 0; i < 16; i++) begin
      logic g;
      rd_idx = 4'(i); #1;
      g = m_lo0[i][0] & m_lo1[i][0];
      chk_rd(rd_lo0, (m_lo0[i] & 32'hC3FF_FFFE) | 32'(g), "R12/R13");
      chk_rd(rd_lo1, (m_lo1[i] & 32'hC3FF_FFFE) | 32'(g), "R12/R13");
      chk_rd({rd_pmask, rd_asid, 12'(rd_vpn2)}, {m_pm[i], m_asid[i], 12'(m_vpn2[i])}, "R13");
      @(negedge clk);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule